// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the word a host sees when it reads a dual-bank flash while an embedded program or erase is running. Each read strobe carries an address. The block works out which bank and which erase sector that address falls in. From the operation flags supplied by the bank's controller, it then decides whether the read returns plain array data or a status word. A status word carries three status bits: a data-polling bit, a per-read toggle bit and a second toggle bit. Any bit of the word that is not a status bit carries array data.

The block also drives an active-low busy output. The busy output is low while a program or an active erase is in progress. During an erase suspend with no program running, it reads as ready. Array storage and the operation timers sit outside the block. The flags come in as level inputs, and the array word comes in already fetched for the strobed address.

Top module: `flash_status_gen`

## Requirements
- R1: While a program runs and the read address is in the busy bank, outside any suspended sector, bit 7 of the returned word is the inverse of `wr_data_b7`. The other non-status bits carry `array_data`.
- R2: While an erase runs (`erase_busy` high, `erase_susp` low) and the read address is in the busy bank, bit 7 reads 0. After the erase ends, reads return `array_data` unchanged.
- R3: Bit 6 follows a toggle register that starts at 0 and inverts after every strobed read that returns program or erase status.
- R4: During an erase suspend, a read whose sector index (`rd_addr[ADDR_W-1:SECT_SHIFT]`) equals `susp_sector`, in the busy bank, returns bit 7 = 1 and bit 6 = 1. Bit 2 carries the second toggle register.
- R5: Bit 2 follows a second toggle register that starts at 0. That register inverts after strobed reads returning erase or suspended-sector status, and holds across program-status reads.
- R6: A read whose bank (bank 1 when `rd_addr >= BANK_BASE`, otherwise bank 0) differs from `op_bank` returns `array_data` unchanged, whatever the flags. So does a read of a non-suspended sector during suspend with no program running.
- R7: `busy_n` is registered. One cycle after the flags it is 0 when `prog_busy` is high, or when `erase_busy` is high with `erase_susp` low. Otherwise it is 1.
- R8: A program running during erase suspend, read at a non-suspended sector of the busy bank, returns program status: bit 7 inverted, bit 6 toggling.
- R9: `rd_data` updates only on the clock edge that samples `rd_strobe` high, and holds otherwise. The toggle registers never advance without a strobe.
- R10: `rst_n` low clears `rd_data` to 0 and both toggle registers to 0, and sets `busy_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_busy | input | 1 | Program operation in progress |
| erase_busy | input | 1 | Erase operation started |
| erase_susp | input | 1 | Erase is suspended |
| op_bank | input | 1 | Bank holding the running operation |
| susp_sector | input | ADDR_W-SECT_SHIFT | Sector index under suspended erase |
| wr_data_b7 | input | 1 | Bit 7 of the word being programmed |
| rd_strobe | input | 1 | Read request, one cycle |
| rd_addr | input | ADDR_W | Read word address |
| array_data | input | DATA_W | Array word at rd_addr |
| rd_data | output | DATA_W | Registered read result |
| busy_n | output | 1 | Active-low busy |

## Verification
Both results take exactly one clock. `rd_data` shows the value for a strobe on the edge that samples it. `busy_n` follows the flags one edge after they change. The bench changes inputs on falling edges and waits two edges after a flag change before it strobes. It checks on the falling edge after the sampling edge, so no check straddles the register. The expected words in the table are worked out from a running account of both toggle registers, and hold checks sample `rd_data` after clocks with no strobe.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;
   localparam int TOG2_BIT = 2;
   localparam int N_TOG    = 2;

   typedef enum logic [1:0] {
      RK_ARRAY = 2'd0,
      RK_PROG  = 2'd1,
      RK_ERASE = 2'd2,
      RK_SUSP  = 2'd3
   } rd_kind_e;
endpackage

// File: rtl/fsg_classify.sv
module fsg_classify
   import fsg_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int SECT_SHIFT = 11,
   parameter int BANK_BASE  = 'h180000,
   localparam int SECT_W    = ADDR_W - SECT_SHIFT
) (
   input  logic              prog_busy,
   input  logic              erase_busy,
   input  logic              erase_susp,
   input  logic              op_bank,
   input  logic [SECT_W-1:0] susp_sector,
   input  logic [ADDR_W-1:0] rd_addr,
   output rd_kind_e          kind
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BANK_BASE);

   logic addr_bank;
   logic in_bank;
   logic in_susp;

   assign addr_bank = (rd_addr >= BASE_V);
   assign in_bank   = (addr_bank == op_bank);
   assign in_susp   = erase_susp && (rd_addr[ADDR_W-1:SECT_SHIFT] == susp_sector);

   always_comb begin
      if (!in_bank)                      kind = RK_ARRAY;
      else if (in_susp)                  kind = RK_SUSP;
      else if (prog_busy)                kind = RK_PROG;
      else if (erase_busy && !erase_susp) kind = RK_ERASE;
      else                               kind = RK_ARRAY;
   end
endmodule

// File: rtl/fsg_toggles.sv
module fsg_toggles
   import fsg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_strobe,
   input  rd_kind_e         kind,
   output logic [N_TOG-1:0] tog_q
);
   logic [N_TOG-1:0] adv;

   // index 0 drives bit 6, index 1 drives bit 2
   assign adv[0] = rd_strobe && ((kind == RK_PROG) || (kind == RK_ERASE));
   assign adv[1] = rd_strobe && ((kind == RK_ERASE) || (kind == RK_SUSP));

   for (genvar i = 0; i < N_TOG; i++) begin : g_tog
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      tog_q[i] <= 1'b0;
         else if (adv[i]) tog_q[i] <= ~tog_q[i];
      end
   end
endmodule

// File: rtl/fsg_compose.sv
module fsg_compose
   import fsg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  rd_kind_e          kind,
   input  logic [DATA_W-1:0] array_data,
   input  logic              wr_data_b7,
   input  logic [N_TOG-1:0]  tog_q,
   output logic [DATA_W-1:0] word
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         always_comb begin
            case (kind)
               RK_PROG:  word[b] = ~wr_data_b7;
               RK_ERASE: word[b] = 1'b0;
               RK_SUSP:  word[b] = 1'b1;
               default:  word[b] = array_data[b];
            endcase
         end
      end else if (b == TOG_BIT) begin : g_tog
         always_comb begin
            case (kind)
               RK_PROG, RK_ERASE: word[b] = tog_q[0];
               RK_SUSP:           word[b] = 1'b1;
               default:           word[b] = array_data[b];
            endcase
         end
      end else if (b == TOG2_BIT) begin : g_tog2
         always_comb begin
            if (kind == RK_ARRAY) word[b] = array_data[b];
            else                  word[b] = tog_q[1];
         end
      end else begin : g_pass
         assign word[b] = array_data[b];
      end
   end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsg_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 21,
   parameter int SECT_SHIFT = 11,
   parameter int BANK_BASE  = 'h180000,
   localparam int SECT_W    = ADDR_W - SECT_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_busy,
   input  logic              erase_busy,
   input  logic              erase_susp,
   input  logic              op_bank,
   input  logic [SECT_W-1:0] susp_sector,
   input  logic              wr_data_b7,
   input  logic              rd_strobe,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy_n
);
   if (DATA_W < POLL_BIT + 1) begin : g_chk_w
      $error("DATA_W must hold the status bits");
   end
   if (SECT_SHIFT < 1 || SECT_SHIFT >= ADDR_W) begin : g_chk_s
      $error("SECT_SHIFT out of range");
   end
   if (BANK_BASE <= 0 || BANK_BASE >= (1 << ADDR_W)) begin : g_chk_b
      $error("BANK_BASE outside address space");
   end

   rd_kind_e          kind;
   logic [N_TOG-1:0]  tog_q;
   logic [DATA_W-1:0] word;

   fsg_classify #(
      .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .BANK_BASE(BANK_BASE)
   ) u_cls (
      .prog_busy(prog_busy), .erase_busy(erase_busy), .erase_susp(erase_susp),
      .op_bank(op_bank), .susp_sector(susp_sector), .rd_addr(rd_addr),
      .kind(kind)
   );

   fsg_toggles u_tog (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .kind(kind), .tog_q(tog_q)
   );

   fsg_compose #(.DATA_W(DATA_W)) u_cmp (
      .kind(kind), .array_data(array_data), .wr_data_b7(wr_data_b7),
      .tog_q(tog_q), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         busy_n  <= 1'b1;
      end else begin
         if (rd_strobe) rd_data <= word;
         busy_n <= ~(prog_busy || (erase_busy && !erase_susp));
      end
   end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 21,
   parameter int BANK_BASE = 'h180000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_busy,
   input logic              erase_busy,
   input logic              erase_susp,
   input logic              op_bank,
   input logic              wr_data_b7,
   input logic              rd_strobe,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy_n
);
   logic hit;
   assign hit = ((rd_addr >= ADDR_W'(BANK_BASE)) == op_bank);

   AST_BUSY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |=> !busy_n); // R7
   AST_READY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_susp && !prog_busy) |=> busy_n); // R7
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !prog_busy && !erase_busy && !erase_susp) |=> rd_data == $past(array_data)); // R6
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_data)); // R9
   AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && hit && prog_busy && !erase_busy && !erase_susp) |=> rd_data[7] == !$past(wr_data_b7)); // R1
   AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && hit && erase_busy && !erase_susp && !prog_busy) |=> !rd_data[7]); // R2
endmodule

bind flash_status_gen fsg_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
   .erase_susp(erase_susp), .op_bank(op_bank), .wr_data_b7(wr_data_b7),
   .rd_strobe(rd_strobe), .rd_addr(rd_addr), .array_data(array_data),
   .rd_data(rd_data), .busy_n(busy_n)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
   localparam int DW = 16, AW = 21, SS = 11, SW = AW - SS;

   logic clk = 1'b0, rst_n = 1'b0;
   logic prog_busy = 0, erase_busy = 0, erase_susp = 0, op_bank = 0, wr_data_b7 = 0;
   logic rd_strobe = 0;
   logic [SW-1:0] susp_sector = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] array_data = '0;
   logic [DW-1:0] rd_data;
   logic busy_n;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   flash_status_gen uut (
      .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
      .erase_susp(erase_susp), .op_bank(op_bank), .susp_sector(susp_sector),
      .wr_data_b7(wr_data_b7), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
      .array_data(array_data), .rd_data(rd_data), .busy_n(busy_n)
   );

   typedef struct packed {
      logic          pb, eb, es, ob;
      logic [SW-1:0] ssec;
      logic [AW-1:0] addr;
      logic [DW-1:0] arr;
      logic          b7;
      logic [DW-1:0] exp_d;
      logic          exp_b;
      logic [3:0]    req;
   } vec_t;

   // toggle state before each row noted as (bit6 reg, bit2 reg)
   localparam vec_t TBL [12] = '{
      '{0,0,0,0, 10'd0, 21'h000100, 16'hA5A5, 1, 16'hA5A5, 1, 4'd6},  // R6 idle (0,0)
      '{1,0,0,0, 10'd0, 21'h000100, 16'hA5A5, 1, 16'hA521, 0, 4'd1},  // R1 (0,0)
      '{1,0,0,0, 10'd0, 21'h000100, 16'hA5A5, 1, 16'hA561, 0, 4'd3},  // R3 R5 (1,0)
      '{1,0,0,0, 10'd0, 21'h180000, 16'hA5A5, 1, 16'hA5A5, 0, 4'd6},  // R6 other bank
      '{0,1,0,0, 10'd0, 21'h000200, 16'hA5A5, 1, 16'hA521, 0, 4'd2},  // R2 (0,0)
      '{0,1,0,0, 10'd0, 21'h000200, 16'hA5A5, 1, 16'hA565, 0, 4'd5},  // R5 (1,1)
      '{0,1,1,0, 10'd1, 21'h000800, 16'hA5A5, 1, 16'hA5E1, 1, 4'd4},  // R4 (0,0)
      '{0,1,1,0, 10'd1, 21'h000800, 16'hA5A5, 1, 16'hA5E5, 1, 4'd4},  // R4 (0,1)
      '{0,1,1,0, 10'd1, 21'h001000, 16'hA5A5, 1, 16'hA5A5, 1, 4'd6},  // R6 non-suspended
      '{1,1,1,0, 10'd1, 21'h001000, 16'hA5A5, 1, 16'hA521, 0, 4'd8},  // R8 (0,0)
      '{1,1,1,0, 10'd1, 21'h001000, 16'hA5A5, 1, 16'hA561, 0, 4'd8},  // R8 (1,0)
      '{0,0,0,0, 10'd1, 21'h000100, 16'hA5A5, 1, 16'hA5A5, 1, 4'd2}   // R2 done
   };

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic strobe();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset rd_data", rd_data, '0);
      check("R10 reset busy_n", {15'd0, busy_n}, 16'd1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 12; i++) begin
         prog_busy = TBL[i].pb; erase_busy = TBL[i].eb; erase_susp = TBL[i].es;
         op_bank = TBL[i].ob; susp_sector = TBL[i].ssec; rd_addr = TBL[i].addr;
         array_data = TBL[i].arr; wr_data_b7 = TBL[i].b7;
         repeat (2) @(negedge clk);
         strobe();
         check($sformatf("R%0d row %0d data", TBL[i].req, i), rd_data, TBL[i].exp_d);
         check($sformatf("R7 row %0d busy_n", i), {15'd0, busy_n}, {15'd0, TBL[i].exp_b});
      end

      // R9: no strobe -> data held and toggles idle
      prog_busy = 1; rd_addr = 21'h000100; array_data = 16'h0F0F;
      repeat (6) @(negedge clk);
      check("R9 hold without strobe", rd_data, 16'hA5A5);
      array_data = 16'hA5A5;
      strobe();
      check("R9 toggle idle across clocks", rd_data, 16'hA521);
      strobe();
      check("R3 toggle again", rd_data, 16'hA561);
      strobe();
      check("R3 toggle back", rd_data, 16'hA521);
      // bit6 register now 1; reset must clear it
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 mid-op reset rd_data", rd_data, '0);
      check("R10 mid-op reset busy_n", {15'd0, busy_n}, 16'd1);
      rst_n = 1'b1;
      @(negedge clk);
      strobe();
      check("R10 toggle cleared", rd_data, 16'hA521);
      // R1 with write bit 0: bit7 reads 1
      wr_data_b7 = 0; array_data = 16'h0000;
      @(negedge clk);
      strobe();
      check("R1 complement of zero", rd_data, 16'h00C0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule